// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes on one asynchronous serial line. It has two stages. A holding register takes bytes from a register write port. A shift register then serializes the current frame. When the shifter becomes free, the pending byte moves from the holding register into the shifter in a single cycle. Software therefore gets a whole frame time to supply the next byte, and back-to-back frames go out with no idle bit between them.

An `hold_empty` status bit tells software when the holding register can take a new byte. The write port is never blocked. If a second byte is written before the hand-off, it replaces the pending byte, and the earlier byte is never sent.

The bit rate comes from an external one-cycle `baud_tick` pulse. Each bit stays on the line until the next tick.

The shifter is a five-state machine:

- **ST_IDLE**: the line is high. It moves to ST_START in the cycle it sees a pending byte.
- **ST_START**: drives the start bit. It moves to ST_DATA on a tick.
- **ST_DATA**: drives the data bits. It stays here for eight ticks, then moves to ST_PARITY, or to ST_STOP when parity is disabled.
- **ST_PARITY**: drives the parity bit. It moves to ST_STOP on a tick.
- **ST_STOP**: drives the stop bit. On a tick it moves to ST_START if a byte is pending, otherwise to ST_IDLE.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset, `hold_empty` is 1, `busy` is 0 and `txd` is 1.
- R2: A cycle with `wr_en` high makes `hold_empty` read 0 in the next cycle. This holds even if a hand-off happens in the same cycle.
- R3: With the shifter idle, a pending byte is handed off in the cycle after the write. One cycle after that hand-off, `hold_empty` is 1 and `busy` is 1.
- R4: Writes are accepted whatever the value of `hold_empty`. A byte written while another byte is still pending replaces it. Only the newest byte is transmitted.
- R5: A frame is one start bit (0), then the eight data bits LSB first, then one parity bit, then one stop bit (1). Each bit is held from one baud tick to the next. With the defaults (PARITY_EN=1, PARITY_ODD=0) the parity bit is the XOR of the data bits, which gives even parity.
- R6: If a byte is pending when the stop bit ends, its start bit follows immediately, with no idle bit between the frames.
- R7: `busy` is 1 for every bit of a frame and 0 when the shifter is idle.
- R8: When `busy` is 0, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| baud_tick | input | 1 | One-cycle pulse that ends the current bit |
| hold_empty | output | 1 | 1 when the holding register has no pending byte |
| busy | output | 1 | 1 while a frame is being shifted |
| txd | output | 1 | Serial line, idles high |

## Verification
Each of these internal faults shows up at the ports within a known time:

- **Empty flag stuck**: if the flag stops tracking the holding register, `hold_empty` reads wrong in the first cycle after a write or after a hand-off.
- **Lost or duplicated hand-off**: the serial stream carries a missing, repeated or stale byte, which is visible by the stop bit of the next frame.
- **Bit counter or shift-order slip**: a wrong data bit appears at the first affected tick, and the parity or stop bit of the same frame comes out wrong.
- **Late reload after the stop bit**: an idle bit appears between streamed frames, which is visible at the next start bit.

// File: rtl/dbuf_tx_pkg.sv
package dbuf_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              empty
);

    // A write always wins: a byte written in the hand-off cycle stays pending.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            empty     <= 1'b1;
        end else if (wr_en) begin
            hold_data <= wr_data;
            empty     <= 1'b0;
        end else if (take) begin
            empty     <= 1'b1;
        end
    end

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import dbuf_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter bit PARITY_EN  = 1'b1,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              pend_valid,
    input  logic [DATA_W-1:0] pend_data,
    output logic              take,
    output logic              busy,
    output logic              txd
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tx_state_e         st_q, st_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              par_q, par_d;
    tx_state_e         after_data;

    // Parameter picks whether a parity slot follows the data bits.
    generate
        if (PARITY_EN) begin : g_par
            assign after_data = ST_PARITY;
        end else begin : g_nopar
            assign after_data = ST_STOP;
        end
    endgenerate

    // Hand-off when idle, or at the tick that ends a stop bit.
    assign take = pend_valid &&
                  ((st_q == ST_IDLE) || ((st_q == ST_STOP) && baud_tick));

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        sh_d  = sh_q;
        cnt_d = cnt_q;
        par_d = par_q;
        if (take) begin
            st_d  = ST_START;
            sh_d  = pend_data;
            cnt_d = '0;
            par_d = (^pend_data) ^ PARITY_ODD;
        end else if (baud_tick) begin
            unique case (st_q)
                ST_IDLE:   st_d = ST_IDLE;
                ST_START:  st_d = ST_DATA;
                ST_DATA: begin
                    sh_d  = sh_q >> 1;
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q == LAST_BIT) begin
                        st_d = after_data;
                    end
                end
                ST_PARITY: st_d = ST_STOP;
                ST_STOP:   st_d = ST_IDLE;
                default:   st_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            sh_q  <= '0;
            cnt_q <= '0;
            par_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            sh_q  <= sh_d;
            cnt_q <= cnt_d;
            par_q <= par_d;
        end
    end

    // Outputs
    always_comb begin
        busy = 1'b1;
        txd  = 1'b1;
        unique case (st_q)
            ST_IDLE:   busy = 1'b0;
            ST_START:  txd  = 1'b0;
            ST_DATA:   txd  = sh_q[0];
            ST_PARITY: txd  = par_q;
            ST_STOP:   txd  = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
    parameter int DATA_W     = 8,
    parameter bit PARITY_EN  = 1'b1,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    output logic              hold_empty,
    output logic              busy,
    output logic              txd
);

    logic [DATA_W-1:0] hold_data;
    logic              take;

    tx_hold_reg #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .hold_data (hold_data),
        .empty     (hold_empty)
    );

    tx_shifter #(
        .DATA_W     (DATA_W),
        .PARITY_EN  (PARITY_EN),
        .PARITY_ODD (PARITY_ODD)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .pend_valid (!hold_empty),
        .pend_data  (hold_data),
        .take       (take),
        .busy       (busy),
        .txd        (txd)
    );

endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic baud_tick,
    input logic hold_empty,
    input logic busy,
    input logic txd
);

    AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty); // R2

    AST_IDLE_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && !busy && !wr_en) |=> (hold_empty && busy)); // R3

    AST_EMPTY_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> busy); // R3

    AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> $stable(txd)); // R5

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd); // R5

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R8

endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk u_chk (.*);

// File: tb/dbuf_uart_tx_test.sv
module dbuf_uart_tx_test;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic       hold_empty, busy, txd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    bit         rx_active = 0;
    int         rx_idx = 0;
    logic [7:0] rx_data = '0;
    int         gap = 0;
    bit         chk_gap = 0;
    int         stream_frames = 0;

    always #2.5 clk = ~clk;

    dbuf_uart_tx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .baud_tick  (baud_tick),
        .hold_empty (hold_empty),
        .busy       (busy),
        .txd        (txd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Serial receiver model, sampled at each tick just before it takes effect.
    task automatic sample_bit();
        if (!rx_active) begin
            if (txd == 1'b0) begin
                rx_active = 1;
                rx_idx = 0;
                if (chk_gap && stream_frames > 0)
                    check(gap == 0, "R6 idle bits between frames", gap, 0);
                gap = 0;
            end else begin
                gap++;
            end
        end else begin
            check(busy == 1'b1, "R7 busy during frame", busy, 1);
            if (rx_idx < 8) begin
                rx_data[rx_idx] = txd;
            end else if (rx_idx == 8) begin
                check(txd == ^rx_data, "R5 parity bit", txd, ^rx_data);
            end else begin
                check(txd == 1'b1, "R5 stop bit", txd, 1);
                if (exp_q.size() == 0) begin
                    check(0, "R4 unexpected frame", rx_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rx_data == e, "R5 R4 received byte", rx_data, e);
                end
                rx_active = 0;
                if (chk_gap) stream_frames++;
            end
            rx_idx++;
        end
    endtask

    // Tick generator and sampler in one process: no race at the edge.
    initial begin
        int tdiv = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                tdiv = 0;
                baud_tick = 1'b0;
            end else if (tdiv == DIV - 1) begin
                sample_bit();
                baud_tick = 1'b1;
                tdiv = 0;
            end else begin
                baud_tick = 1'b0;
                tdiv++;
            end
        end
    end

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !busy && !rx_active) break;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(hold_empty == 1'b1, "R1 empty at reset", hold_empty, 1);
        check(busy == 1'b0, "R1 busy at reset", busy, 0);
        check(txd == 1'b1, "R1 txd at reset", txd, 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(txd == 1'b1, "R8 idle line", txd, 1);

        // Single write with an idle shifter.
        wr(8'hA5);
        exp_q.push_back(8'hA5);
        check(hold_empty == 1'b0, "R2 write clears empty", hold_empty, 0);
        @(negedge clk);
        check(hold_empty == 1'b1, "R3 empty after hand-off", hold_empty, 1);
        check(busy == 1'b1, "R3 busy after hand-off", busy, 1);
        wait_done();
        check(busy == 1'b0, "R7 busy low when idle", busy, 0);
        check(txd == 1'b1, "R8 line high when idle", txd, 1);

        // Overwrite of a pending byte.
        wr(8'h3C);
        exp_q.push_back(8'h3C);
        wr(8'h11);
        check(hold_empty == 1'b0, "R4 first pending write", hold_empty, 0);
        wr(8'h96);
        check(hold_empty == 1'b0, "R4 overwrite accepted", hold_empty, 0);
        exp_q.push_back(8'h96);
        wait_done();
        check(exp_q.size() == 0, "R4 only newest byte sent", exp_q.size(), 0);

        // Streaming sweep over all byte values.
        chk_gap = 1;
        stream_frames = 0;
        for (int v = 0; v < 256; v++) begin
            for (int k = 0; k < 1000 && !hold_empty; k++) @(negedge clk);
            wr(8'(v));
            exp_q.push_back(8'(v));
            check(hold_empty == 1'b0, "R2 write clears empty in stream", hold_empty, 0);
        end
        wait_done();
        chk_gap = 0;
        check(stream_frames == 256, "R6 all streamed frames received", stream_frames, 256);
        check(hold_empty == 1'b1, "R3 empty after stream", hold_empty, 1);
        check(txd == 1'b1, "R8 line high after stream", txd, 1);
        finish_run();
    end

endmodule